// File: doc/BRIEF.md
# Inclusion-Counter Replacement Selector

This block holds the replacement bookkeeping of a fully associative parent cache that is shared by several child caches. Each parent block has a small residency counter that records how many children currently hold a copy of it. A child fill of a block raises that block's count, and a child eviction notice lowers it. A block that no child holds has a count of zero and can be replaced without breaking inclusion.

When the parent needs room, a victim request picks the lowest-indexed block whose count is zero. If no such block exists, a pseudo-random block is taken from a free-running shift register and a flag reports that the fallback path was used. A one-cycle notify pulse carries the chosen block index toward the next level up. Tag matching, data storage and the coherence protocol sit outside this block, which sees only block indices.

Top module: `incl_victim_sel`

## Requirements
- R1: After reset every residency count is zero, all outputs are low, and a first victim request returns index 0 with the zero-pool flag set.
- R2: A fill of block k, with no eviction of k in the same cycle, raises the count of k by one.
- R3: An eviction notice for block k, with no fill of k in the same cycle, lowers the count of k by one.
- R4: A victim request picks the lowest index whose count is zero, sets victim_zero and clears victim_fallback.
- R5: A fill and an eviction of the same block in one cycle leave its count unchanged and raise no error.
- R6: A fill of a block whose count already equals the number of children leaves the count at that value and drives cnt_err high for exactly the next cycle.
- R7: An eviction of a block whose count is zero leaves the count at zero and drives cnt_err high for exactly the next cycle.
- R8: When no count is zero, the victim index is the fallback register value modulo the block count, with victim_fallback high and victim_zero low. The register is 16 bits, loads 0xACE1 in reset, and on every clock after reset shifts left by one with bit 0 taking bit15 XOR bit13 XOR bit12 XOR bit10.
- R9: notify_vld is high in the cycle after each victim request and low otherwise; victim_idx and both flags are zero whenever notify_vld is low.
- R10: A victim request is decided on the counts held before any fill or eviction arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_vld | input | 1 | A child loaded a block from this parent |
| fill_idx | input | IDX_W | Index of the filled block |
| evict_vld | input | 1 | A child reports it dropped a block |
| evict_idx | input | IDX_W | Index of the dropped block |
| victim_req | input | 1 | Request for a replacement victim |
| notify_vld | output | 1 | One-cycle pulse announcing the replaced block upward |
| victim_idx | output | IDX_W | Chosen victim index |
| victim_zero | output | 1 | Victim came from the zero-count pool |
| victim_fallback | output | 1 | Victim came from the pseudo-random fallback |
| cnt_err | output | 1 | A fill beyond the child count or an eviction below zero was seen |

## Verification
The properties assume that block indices on fill_idx and evict_idx are below the block count and that the surrounding cache never issues a request while reset is asserted. The stimulus only drives indices inside the array and keeps all strobes low until reset is released at a falling edge. Saturation cases are reached on purpose by over-filling one block and evicting an empty one, so the error properties are exercised rather than only assumed.

// File: rtl/incl_pkg.sv
package incl_pkg;
    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    function automatic logic [15:0] lfsr_advance(input logic [15:0] cur);
        logic fb;
        fb = cur[15] ^ cur[13] ^ cur[12] ^ cur[10];
        return {cur[14:0], fb};
    endfunction
endpackage

// File: rtl/incl_lfsr.sv
module incl_lfsr
    import incl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] value
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_advance(lfsr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= LFSR_SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;

    assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/incl_cnt_bank.sv
module incl_cnt_bank #(
    parameter int NUM_BLOCKS   = 16,
    parameter int NUM_CHILDREN = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fill_vld,
    input  logic [$clog2(NUM_BLOCKS)-1:0] fill_idx,
    input  logic                          evict_vld,
    input  logic [$clog2(NUM_BLOCKS)-1:0] evict_idx,
    output logic [NUM_BLOCKS-1:0]         zero_vec,
    output logic                          err
);
    localparam int CW = $clog2(NUM_CHILDREN + 1);
    localparam int IW = $clog2(NUM_BLOCKS);
    localparam logic [CW-1:0] CNT_MAX = CW'(NUM_CHILDREN);

    typedef struct packed {
        logic [NUM_BLOCKS-1:0][CW-1:0] cnt;
        logic                          err;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d     = bank_q;
        bank_d.err = 1'b0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            logic inc, dec;
            inc = fill_vld  && (fill_idx  == IW'(i));
            dec = evict_vld && (evict_idx == IW'(i));
            if (inc && !dec) begin
                if (bank_q.cnt[i] == CNT_MAX) bank_d.err = 1'b1;
                else bank_d.cnt[i] = bank_q.cnt[i] + 1'b1;
            end else if (dec && !inc) begin
                if (bank_q.cnt[i] == '0) bank_d.err = 1'b1;
                else bank_d.cnt[i] = bank_q.cnt[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_zero
        assign zero_vec[g] = (bank_q.cnt[g] == '0);
    end
    assign err = bank_q.err;

    assert_fill_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld && !(evict_vld && evict_idx == fill_idx)
         && bank_q.cnt[fill_idx] == CNT_MAX) |=> err);

    assert_evict_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_vld && !(fill_vld && evict_idx == fill_idx)
         && zero_vec[evict_idx]) |=> (err && zero_vec[$past(evict_idx)]));

    assert_pair_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld && evict_vld && fill_idx == evict_idx) |=>
        (!err && $stable(bank_q.cnt)));

    assert_quiet_inputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_vld && !evict_vld) |=> (!err && $stable(zero_vec)));
endmodule

// File: rtl/incl_zero_pick.sv
module incl_zero_pick #(
    parameter int NUM_BLOCKS = 16
) (
    input  logic [NUM_BLOCKS-1:0]         zero_vec,
    output logic                          found,
    output logic [$clog2(NUM_BLOCKS)-1:0] pick
);
    localparam int IW = $clog2(NUM_BLOCKS);

    always_comb begin
        pick = '0;
        for (int i = NUM_BLOCKS - 1; i >= 0; i--) begin
            if (zero_vec[i]) pick = IW'(i);
        end
    end

    assign found = |zero_vec;
endmodule

// File: rtl/incl_victim_sel.sv
module incl_victim_sel #(
    parameter int NUM_BLOCKS   = 16,
    parameter int NUM_CHILDREN = 3,
    localparam int IDX_W       = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_vld,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             evict_vld,
    input  logic [IDX_W-1:0] evict_idx,
    input  logic             victim_req,
    output logic             notify_vld,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_zero,
    output logic             victim_fallback,
    output logic             cnt_err
);
    import incl_pkg::*;

    typedef struct packed {
        logic             notify;
        logic [IDX_W-1:0] idx;
        logic             zero;
        logic             fallback;
    } pick_t;

    pick_t st_d, st_q;

    logic [NUM_BLOCKS-1:0] zero_vec;
    logic                  found;
    logic [IDX_W-1:0]      pick_idx;
    logic [LFSR_W-1:0]     rnd;

    incl_cnt_bank #(
        .NUM_BLOCKS  (NUM_BLOCKS),
        .NUM_CHILDREN(NUM_CHILDREN)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_vld (fill_vld),
        .fill_idx (fill_idx),
        .evict_vld(evict_vld),
        .evict_idx(evict_idx),
        .zero_vec (zero_vec),
        .err      (cnt_err)
    );

    incl_zero_pick #(.NUM_BLOCKS(NUM_BLOCKS)) u_pick (
        .zero_vec(zero_vec),
        .found   (found),
        .pick    (pick_idx)
    );

    incl_lfsr u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .value(rnd)
    );

    always_comb begin
        st_d = '0;
        if (victim_req) begin
            st_d.notify = 1'b1;
            if (found) begin
                st_d.idx  = pick_idx;
                st_d.zero = 1'b1;
            end else begin
                st_d.idx      = IDX_W'(rnd % LFSR_W'(NUM_BLOCKS));
                st_d.fallback = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign notify_vld      = st_q.notify;
    assign victim_idx      = st_q.idx;
    assign victim_zero     = st_q.zero;
    assign victim_fallback = st_q.fallback;

    assert_notify_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        victim_req |=> notify_vld);

    assert_notify_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !victim_req |=> (!notify_vld && victim_idx == '0
                         && !victim_zero && !victim_fallback));

    assert_flag_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        notify_vld |-> $onehot({victim_zero, victim_fallback}));

    assert_pick_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> zero_vec[pick_idx]);

    assert_fallback_nofree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_req && !found) |=> victim_fallback);
endmodule

// File: tb/incl_victim_sel_tb.sv
module incl_victim_sel_tb;
    localparam int NB  = 16;
    localparam int NCH = 3;
    localparam int IW  = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_vld = 1'b0, evict_vld = 1'b0, victim_req = 1'b0;
    logic [IW-1:0] fill_idx = '0, evict_idx = '0;
    logic          notify_vld, victim_zero, victim_fallback, cnt_err;
    logic [IW-1:0] victim_idx;

    always #2.5 clk = ~clk;

    incl_victim_sel #(.NUM_BLOCKS(NB), .NUM_CHILDREN(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .fill_vld(fill_vld), .fill_idx(fill_idx),
        .evict_vld(evict_vld), .evict_idx(evict_idx),
        .victim_req(victim_req),
        .notify_vld(notify_vld), .victim_idx(victim_idx),
        .victim_zero(victim_zero), .victim_fallback(victim_fallback),
        .cnt_err(cnt_err)
    );

    typedef struct {
        int    idx;
        bit    zero;
        bit    fb;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_chk = 0, n_fail = 0;
    int    cnt_m [NB];
    bit    exp_err = 1'b0;
    string err_tag = "R1";
    bit    done = 1'b0;
    logic [15:0] lfsr_m;

    // Independent model of the fallback register from R8
    always @(posedge clk) begin
        if (!rst_n) lfsr_m <= 16'hACE1;
        else lfsr_m <= {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit fv, input int fi, input bit ev, input int ei,
                        input bit rq, input string tag);
        exp_t e;
        bit   over, under, pair;
        @(negedge clk);
        fill_vld   = fv; fill_idx  = IW'(fi);
        evict_vld  = ev; evict_idx = IW'(ei);
        victim_req = rq;
        if (rq) begin
            e.idx = -1; e.zero = 1'b0; e.fb = 1'b0; e.tag = tag;
            for (int i = NB - 1; i >= 0; i--) if (cnt_m[i] == 0) e.idx = i;
            if (e.idx >= 0) e.zero = 1'b1;
            else begin
                e.idx = int'(lfsr_m) % NB;
                e.fb  = 1'b1;
            end
            sb_q.push_back(e);
        end
        pair = fv && ev && fi == ei;
        over = 1'b0; under = 1'b0;
        if (fv && !pair) begin
            if (cnt_m[fi] == NCH) over = 1'b1; else cnt_m[fi]++;
        end
        if (ev && !pair) begin
            if (cnt_m[ei] == 0) under = 1'b1; else cnt_m[ei]--;
        end
        exp_err = over || under;
        err_tag = over ? "R6" : under ? "R7" : pair ? "R5" : "R2";
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, "R9");
    endtask

    // Monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(cnt_err == exp_err, err_tag, "cnt_err", int'(cnt_err), int'(exp_err));
            if (notify_vld) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected notify", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(int'(victim_idx) == e.idx, e.tag, "victim_idx", int'(victim_idx), e.idx);
                    check(victim_zero == e.zero, e.tag, "victim_zero", int'(victim_zero), int'(e.zero));
                    check(victim_fallback == e.fb, e.tag, "victim_fallback", int'(victim_fallback), int'(e.fb));
                end
            end else begin
                check(sb_q.size() == 0, "R9", "missing notify", 0, 1);
                check(victim_idx == '0 && !victim_zero && !victim_fallback, "R9",
                      "outputs idle", int'(victim_idx), 0);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) cnt_m[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!notify_vld && !cnt_err && victim_idx == '0 && !victim_zero && !victim_fallback,
              "R1", "reset outputs", int'(notify_vld), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 1, "R1");              // first victim: block 0
        step(1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 1, "R2");              // block 0 held -> 1
        step(1, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, "R2");              // count 3 = children
        step(1, 0, 0, 0, 0, "R6");              // overflow attempt
        idle(1);
        step(0, 0, 1, 5, 0, "R7");              // underflow attempt
        step(0, 0, 0, 0, 1, "R7");              // 5 still zero, 1 lowest -> 1
        step(1, 1, 1, 1, 0, "R5");              // same-block pair
        step(0, 0, 0, 0, 1, "R5");              // 1 still zero
        step(1, 1, 0, 0, 0, "R3");
        step(0, 0, 1, 0, 0, "R3");
        step(0, 0, 1, 0, 0, "R3");
        step(0, 0, 1, 0, 0, "R3");              // block 0 back to 0
        step(0, 0, 0, 0, 1, "R3");
        step(1, 0, 0, 0, 1, "R10");             // decided before fill
        for (int b = 2; b < NB; b++) step(1, b, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 1, "R8");              // nothing free
        step(0, 0, 0, 0, 1, "R8");
        idle(2);
        step(0, 0, 0, 0, 1, "R8");
        step(0, 0, 1, 9, 0, "R3");
        step(0, 0, 0, 0, 1, "R4");              // only 9 free
        step(0, 0, 1, 4, 0, "R3");
        step(0, 0, 0, 0, 1, "R4");              // 4 and 9 free -> 4
        step(0, 0, 1, 9, 1, "R10");             // 9 at zero, evict 9 errors; pick 4
        idle(3);
        done = 1'b1;
        check(sb_q.size() == 0, "R9", "scoreboard drained", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule